// File: doc/BRIEF.md
# Prioritized LRU Bus Arbiter with Parking

This block shares one bus among eight masters. Each master has a 3-bit effective level. A per-master select bit decides where that level comes from: a built-in constant, or a field that software writes. The lowest numeric level among the requesters wins. When several requesters tie on the winning level, the one granted longest ago gets the bus.

The winner keeps the grant until it strobes transfer-done. At that strobe the next owner is decided, so one grant waits behind the running transfer and no more.

When no master requests, the grant either drops or is parked on a master:
- the last owner, or
- a master index supplied on a port.

A parked master that starts requesting uses the grant it already holds.

Top module: `lruPrioArbiter`

## Requirements
- R1: The grant vector is one-hot or zero. The grant index equals the position of the set grant bit, and is 0 when no bit is set.
- R2: The effective level of master i is the field at bits [3i+2:3i] of the priority word when bit i of the select word is 1. When that bit is 0, it is the built-in level, which by default is i. A lower value is a higher priority.
- R3: Among requesters tied at the best level, the grant goes to the one least recently granted. After reset the order from oldest is master 0, 1, ..., 7. Every grant issued by arbitration makes the winner the most recent.
- R4: Once a master is granted, the grant vector holds until transfer-done is high at a clock edge. The grant for the next owner appears at the edge where done is sampled.
- R5: A change to the select word or the priority word takes effect at the next arbitration decision. It does not move a grant that is already held.
- R6: With no requests at a decision point, the park mode decides the grant:
  - 0 gives no grant.
  - 1 parks on the last arbitrated owner.
  - 2 parks on the master given by the park-index port.
  - 3 behaves like 0.
- R7: A parked master that raises its request keeps its grant with no idle cycle, unless a higher-priority request is also present. In that case the grant moves to the winner at the next edge.
- R8: Reset clears the grant. Park mode 1 grants nobody until the first arbitrated grant after reset.
- R9: Transfer-done while no master owns the bus has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | 8 | Bus request, one bit per master |
| xferDone | input | 1 | Current owner's transfer completes this cycle |
| prioEn | input | 8 | Per-master select: 1 = programmed level, 0 = built-in level |
| prioFlat | input | 24 | Programmed 3-bit levels, master i at [3i+2:3i] |
| parkMode | input | 2 | 0 none, 1 last owner, 2 programmed index, 3 none |
| parkIdx | input | 3 | Master to park on in mode 2 |
| gntVec | output | 8 | One-hot grant |
| gntIdx | output | 3 | Index of the granted master |

## Verification
The hardest state to reach from the ports is a specific least-recently-granted order. That order is invisible and builds up only through a history of grants. The stimulus table therefore runs an unbroken sequence from reset. It grants masters in a chosen order, then forces full-width and partial ties so that the expected winner follows from that history alone. Parking into a request, and priority rewrites in the middle of a transfer, are then driven as directed steps on top of that known history.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [1:0] {
    PARK_NONE = 2'd0,
    PARK_LAST = 2'd1,
    PARK_PROG = 2'd2,
    PARK_RSVD = 2'd3
  } parkMode_t;

  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } ownState_t;

  typedef struct packed {
    logic arbLoad;    // take the arbitration winner
    logic parkLoad;   // take the parking target
    logic lruUpdate;  // move winner to most recent
  } ctrlStrobes_t;

endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_M = 8,
  parameter int LVL_W = 3,
  parameter int IDX_W = 3,
  parameter logic [NUM_M*LVL_W-1:0] FIXED_LVL = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_M-1:0]       reqVec,
  input  logic [NUM_M-1:0]       prioEn,
  input  logic [NUM_M*LVL_W-1:0] prioFlat,
  input  parkMode_t              parkMode,
  input  logic [IDX_W-1:0]       parkIdx,
  input  ctrlStrobes_t           strobes,
  output logic                   anyReq,
  output logic [NUM_M-1:0]       gntVec,
  output logic [IDX_W-1:0]       gntIdx
);

  logic [LVL_W-1:0] effLvl [NUM_M];
  logic [LVL_W-1:0] bestLvl;
  logic [NUM_M-1:0] candVec;
  logic [NUM_M-1:0] winVec;
  logic [IDX_W-1:0] winIdx;
  logic [NUM_M-1:0] olderQ [NUM_M];

  logic [NUM_M-1:0] gntVecQ;
  logic [IDX_W-1:0] gntIdxQ;
  logic [IDX_W-1:0] lastIdxQ;
  logic             lastValidQ;
  logic [NUM_M-1:0] parkVec;
  logic [IDX_W-1:0] parkSelIdx;

  // Level source per master
  for (genvar g = 0; g < NUM_M; g++) begin : gLvl
    assign effLvl[g] = prioEn[g] ? prioFlat[g*LVL_W +: LVL_W]
                                 : FIXED_LVL[g*LVL_W +: LVL_W];
  end

  assign anyReq = |reqVec;

  always_comb begin
    bestLvl = '1;
    for (int i = 0; i < NUM_M; i++) begin
      if (reqVec[i] && (effLvl[i] < bestLvl)) bestLvl = effLvl[i];
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : gCand
    assign candVec[g] = reqVec[g] && (effLvl[g] == bestLvl);
    // winner is older than every other candidate
    assign winVec[g] = candVec[g] &&
                       (&(olderQ[g] | ~candVec | (NUM_M'(1) << g)));
  end

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (winVec[i]) winIdx = IDX_W'(i);
    end
  end

  // Age matrix: olderQ[i][j] set means i was granted before j
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_M; i++) begin
        for (int j = 0; j < NUM_M; j++) begin
          olderQ[i][j] <= (i < j);
        end
      end
    end else if (strobes.lruUpdate) begin
      for (int i = 0; i < NUM_M; i++) begin
        for (int j = 0; j < NUM_M; j++) begin
          if (IDX_W'(i) == winIdx)      olderQ[i][j] <= 1'b0;
          else if (IDX_W'(j) == winIdx) olderQ[i][j] <= 1'b1;
        end
      end
    end
  end

  // Parking target
  always_comb begin
    parkVec    = '0;
    parkSelIdx = '0;
    unique case (parkMode)
      PARK_LAST: begin
        if (lastValidQ) begin
          parkVec    = NUM_M'(1) << lastIdxQ;
          parkSelIdx = lastIdxQ;
        end
      end
      PARK_PROG: begin
        parkVec    = NUM_M'(1) << parkIdx;
        parkSelIdx = parkIdx;
      end
      default: begin
        parkVec    = '0;
        parkSelIdx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntVecQ    <= '0;
      gntIdxQ    <= '0;
      lastIdxQ   <= '0;
      lastValidQ <= 1'b0;
    end else if (strobes.arbLoad) begin
      gntVecQ    <= NUM_M'(1) << winIdx;
      gntIdxQ    <= winIdx;
      lastIdxQ   <= winIdx;
      lastValidQ <= 1'b1;
    end else if (strobes.parkLoad) begin
      gntVecQ <= parkVec;
      gntIdxQ <= parkSelIdx;
    end
  end

  assign gntVec = gntVecQ;
  assign gntIdx = gntIdxQ;

endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyReq,
  input  logic         xferDone,
  output ctrlStrobes_t strobes,
  output logic         ownBusy
);

  ownState_t stateQ, stateD;
  logic      decide;

  assign decide = (stateQ == OWN_IDLE) || xferDone;

  always_comb begin
    strobes.arbLoad   = decide && anyReq;
    strobes.lruUpdate = decide && anyReq;
    strobes.parkLoad  = decide && !anyReq;
    stateD            = stateQ;
    if (decide) stateD = anyReq ? OWN_BUSY : OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= OWN_IDLE;
    else       stateQ <= stateD;
  end

  assign ownBusy = (stateQ == OWN_BUSY);

endmodule

// File: rtl/lruPrioArbiter.sv
module lruPrioArbiter
  import arbPkg::*;
#(
  parameter int NUM_MASTERS = 8,
  parameter int LVL_W       = 3,
  parameter int IDX_W       = $clog2(NUM_MASTERS),
  parameter logic [NUM_MASTERS*LVL_W-1:0] FIXED_LVL = 24'o76543210
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_MASTERS-1:0]       reqVec,
  input  logic                         xferDone,
  input  logic [NUM_MASTERS-1:0]       prioEn,
  input  logic [NUM_MASTERS*LVL_W-1:0] prioFlat,
  input  logic [1:0]                   parkMode,
  input  logic [IDX_W-1:0]             parkIdx,
  output logic [NUM_MASTERS-1:0]       gntVec,
  output logic [IDX_W-1:0]             gntIdx
);

  ctrlStrobes_t strobes;
  logic         anyReq;
  logic         ownBusy;

  arbControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .xferDone (xferDone),
    .strobes  (strobes),
    .ownBusy  (ownBusy)
  );

  arbDatapath #(
    .NUM_M     (NUM_MASTERS),
    .LVL_W     (LVL_W),
    .IDX_W     (IDX_W),
    .FIXED_LVL (FIXED_LVL)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .prioEn   (prioEn),
    .prioFlat (prioFlat),
    .parkMode (parkMode_t'(parkMode)),
    .parkIdx  (parkIdx),
    .strobes  (strobes),
    .anyReq   (anyReq),
    .gntVec   (gntVec),
    .gntIdx   (gntIdx)
  );

endmodule

// File: rtl/arbChecker.sv
module arbChecker #(
  parameter int NUM_M = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [NUM_M-1:0] reqVec,
  input logic             xferDone,
  input logic [1:0]       parkMode,
  input logic [IDX_W-1:0] parkIdx,
  input logic [NUM_M-1:0] gntVec,
  input logic [IDX_W-1:0] gntIdx,
  input logic             busy
);

  logic decidePt;
  assign decidePt = !busy || xferDone;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));                                                // R1

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (gntVec != '0) |-> gntVec[gntIdx]);                               // R1

  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone) |=> $stable(gntVec));                         // R4

  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (decidePt && (reqVec != '0)) |=> ((gntVec & $past(reqVec)) != '0)); // R4

  AST_NO_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (decidePt && (reqVec == '0) && parkMode[0] == parkMode[1])
      |=> (gntVec == '0));                                            // R6

  AST_PROG_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (decidePt && (reqVec == '0) && (parkMode == 2'd2))
      |=> (gntVec == (NUM_M'(1) << $past(parkIdx))));                 // R6

endmodule

bind lruPrioArbiter arbChecker #(
  .NUM_M (NUM_MASTERS),
  .IDX_W (IDX_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqVec   (reqVec),
  .xferDone (xferDone),
  .parkMode (parkMode),
  .parkIdx  (parkIdx),
  .gntVec   (gntVec),
  .gntIdx   (gntIdx),
  .busy     (ownBusy)
);

// File: tb/sim_lruPrioArbiter.sv
module sim_lruPrioArbiter;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  req;
    logic        done;
    logic [7:0]  en;
    logic [23:0] prio;
    logic [1:0]  mode;
    logic [2:0]  park;
    logic [7:0]  exp;
  } row_t;

  // Sequence from reset; LRU history carries from row to row (R3)
  localparam row_t ROWS [17] = '{
    '{8'h00, 1'b0, 8'h00, 24'h000000, 2'd0, 3'd0, 8'h00}, // idle, no park R6
    '{8'h0C, 1'b0, 8'h00, 24'h000000, 2'd0, 3'd0, 8'h04}, // fixed lvl R2
    '{8'h01, 1'b0, 8'h00, 24'h000000, 2'd0, 3'd0, 8'h04}, // hold R4
    '{8'h01, 1'b1, 8'h00, 24'h000000, 2'd0, 3'd0, 8'h01}, // handover R4
    '{8'hFF, 1'b1, 8'hFF, 24'h000000, 2'd0, 3'd0, 8'h02}, // full tie R3
    '{8'hFF, 1'b1, 8'hFF, 24'h000000, 2'd0, 3'd0, 8'h08}, // full tie R3
    '{8'h0F, 1'b1, 8'hFF, 24'h000000, 2'd0, 3'd0, 8'h04}, // partial tie R3
    '{8'h21, 1'b1, 8'hFF, 24'h6CB6DB, 2'd0, 3'd0, 8'h20}, // programmed R2
    '{8'h81, 1'b1, 8'h01, 24'h000007, 2'd0, 3'd0, 8'h80}, // mixed tie R3
    '{8'h03, 1'b1, 8'h01, 24'h000007, 2'd0, 3'd0, 8'h02}, // mixed src R2
    '{8'h00, 1'b1, 8'h01, 24'h000007, 2'd1, 3'd0, 8'h02}, // park last R6
    '{8'h00, 1'b0, 8'h01, 24'h000007, 2'd2, 3'd6, 8'h40}, // park prog R6
    '{8'h40, 1'b0, 8'h01, 24'h000007, 2'd2, 3'd6, 8'h40}, // no gap R7
    '{8'h40, 1'b0, 8'h01, 24'h000007, 2'd2, 3'd6, 8'h40}, // hold R4
    '{8'h00, 1'b1, 8'h01, 24'h000007, 2'd0, 3'd0, 8'h00}, // release R6
    '{8'h00, 1'b1, 8'h01, 24'h000007, 2'd0, 3'd0, 8'h00}, // idle done R9
    '{8'h30, 1'b0, 8'h00, 24'h000000, 2'd0, 3'd0, 8'h10}  // fixed lvl R2
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  reqVec;
  logic        xferDone;
  logic [7:0]  prioEn;
  logic [23:0] prioFlat;
  logic [1:0]  parkMode;
  logic [2:0]  parkIdx;
  logic [7:0]  gntVec;
  logic [2:0]  gntIdx;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lruPrioArbiter u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .xferDone(xferDone),
    .prioEn(prioEn), .prioFlat(prioFlat), .parkMode(parkMode),
    .parkIdx(parkIdx), .gntVec(gntVec), .gntIdx(gntIdx)
  );

  function automatic logic [2:0] expIndex(input logic [7:0] v);
    logic [2:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  task automatic checkGnt(input logic [7:0] exp, input string tag);
    checks++;
    if (gntVec !== exp || gntIdx !== expIndex(exp)) begin
      failures++;
      $display("FAIL %s: gnt=%h idx=%0d expected gnt=%h idx=%0d",
               tag, gntVec, gntIdx, exp, expIndex(exp));
    end
  endtask

  task automatic drive(input logic [7:0] req, input logic done,
                       input logic [7:0] en, input logic [23:0] prio,
                       input logic [1:0] mode, input logic [2:0] park);
    @(negedge clk);
    reqVec = req; xferDone = done; prioEn = en;
    prioFlat = prio; parkMode = mode; parkIdx = park;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqVec = '0; xferDone = 1'b0; prioEn = '0;
    prioFlat = '0; parkMode = 2'd0; parkIdx = '0;
    repeat (3) @(posedge clk);
    #1;
    checkGnt(8'h00, "R8 grant during reset");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    doReset();

    foreach (ROWS[k]) begin
      drive(ROWS[k].req, ROWS[k].done, ROWS[k].en, ROWS[k].prio,
            ROWS[k].mode, ROWS[k].park);
      checkGnt(ROWS[k].exp, $sformatf("R1/R2/R3/R4/R6/R7/R9 row %0d", k));
    end

    // Master 4 owns the bus. Rewrite priorities mid-transfer: no move (R5)
    drive(8'h82, 1'b0, 8'h80, 24'h000000, 2'd0, 3'd0);
    checkGnt(8'h10, "R5 rewrite while owned");
    drive(8'h82, 1'b1, 8'h80, 24'h000000, 2'd0, 3'd0);
    checkGnt(8'h80, "R5 new level at decision");
    // Reserved park mode behaves as none (R6)
    drive(8'h00, 1'b1, 8'h00, 24'h000000, 2'd3, 3'd5);
    checkGnt(8'h00, "R6 reserved mode");

    // After reset, park-last has no target (R8)
    doReset();
    drive(8'h00, 1'b0, 8'h00, 24'h000000, 2'd1, 3'd0);
    checkGnt(8'h00, "R8 park last before any grant");

    // Parked master loses to a higher-priority request (R7)
    drive(8'h00, 1'b0, 8'h00, 24'h000000, 2'd2, 3'd3);
    checkGnt(8'h08, "R7 parked on 3");
    drive(8'h09, 1'b0, 8'h00, 24'h000000, 2'd2, 3'd3);
    checkGnt(8'h01, "R7 higher priority overrides park");

    // Fresh reset order: tie between 5 and 2 goes to 2 (R3)
    drive(8'h24, 1'b1, 8'hFF, 24'h000000, 2'd0, 3'd0);
    checkGnt(8'h04, "R3 reset order tie");

    finish();
  end

endmodule